// File: doc/BRIEF.md
# Bit-Rate Down Counter Timer

This block is a small down counter that steps once per data bit period, not once per system clock. An external bit-rate generator supplies a one-cycle `tick` pulse per bit period, for example at 10 kHz or 8 kHz depending on the air-interface mode. The host writes a coefficient, and that write loads the counter and starts a countdown. The host also selects between a free-running reload mode and a one-shot mode, and controls an interrupt enable.

In reload mode the counter restarts from the stored coefficient each time it reaches zero. `zero_out` is then high for exactly one bit period, from the tick on which the count expires until the next tick. In one-shot mode the counter stops at zero and `zero_out` stays high until the next coefficient write. Each expiry can set a sticky interrupt flag, which the host clears with a pulse.

Top module: `bit_rate_timer`

## Requirements
- R1: After reset, `zero_out` and `irq` are low, and no `tick` causes an expiry until a coefficient has been written.
- R2: After a write of coefficient N (N >= 1) in one-shot mode, `zero_out` goes high in the cycle after the Nth following `tick` and not earlier.
- R3: In cycles without `tick`, `coef_wr` or `irq_clr`, neither `zero_out` nor `irq` changes.
- R4: With `mode_reload` = 1 and coefficient N >= 1, expiry repeats every N ticks. After each expiry `zero_out` is high until the next tick and low at every other tick.
- R5: In one-shot mode, once `zero_out` is high it stays high through further ticks. A coefficient write drives it low in the next cycle.
- R6: A coefficient of 0 expires on the first tick. In reload mode it then expires on every tick, so `zero_out` stays high.
- R7: An expiry while `irq_en` = 1 sets `irq` in the next cycle, and `irq` stays set until cleared.
- R8: `irq_clr` clears `irq` in the next cycle unless an enabled expiry happens in the same cycle, in which case `irq` stays set.
- R9: An expiry while `irq_en` = 0 leaves `irq` low.
- R10: A `coef_wr` in the same cycle as `tick` takes priority: the tick is not counted and the countdown restarts from the new coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per data bit period |
| coef_wr | input | 1 | Coefficient write strobe; loads and starts the counter |
| coef_wdata | input | CNT_W | Coefficient value written with `coef_wr` |
| mode_reload | input | 1 | 1 selects reload mode, 0 selects one-shot mode |
| irq_en | input | 1 | Enables setting of the interrupt flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| zero_out | output | 1 | Expiry indication |
| irq | output | 1 | Sticky interrupt request |

## Verification
A wrong count or a missed reload appears at the ports as a `zero_out` edge on the wrong tick. This is visible within one coefficient period of ticks, at most 256 bit periods. A lost stop flag in one-shot mode shows up on the first tick after expiry, as `zero_out` dropping or expiring again. Interrupt errors show at the first expiry or clear that follows, one cycle after the event.

// File: rtl/bit_rate_timer.sv
module bit_rate_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             coef_wr,
  input  logic [CNT_W-1:0] coef_wdata,
  input  logic             mode_reload,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             zero_out,
  output logic             irq
);
  logic [CNT_W-1:0] coef_q, cnt_q;
  logic             run_q;

  wire last = cnt_q <= CNT_W'(1);
  wire step = tick && run_q && !coef_wr;
  wire hit  = step && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q   <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      zero_out <= 1'b0;
    end else if (coef_wr) begin
      coef_q   <= coef_wdata;
      cnt_q    <= coef_wdata;
      run_q    <= 1'b1;
      zero_out <= 1'b0;
    end else if (step) begin
      zero_out <= last;
      if (!last)
        cnt_q <= cnt_q - CNT_W'(1);
      else if (mode_reload)
        cnt_q <= coef_q;
      else begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              irq <= 1'b0;
    else if (hit && irq_en)  irq <= 1'b1;
    else if (irq_clr)        irq <= 1'b0;
  end
endmodule

// File: rtl/bit_rate_timer_chk.sv
module bit_rate_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic coef_wr,
  input logic mode_reload,
  input logic irq_en,
  input logic irq_clr,
  input logic run_q,
  input logic zero_out,
  input logic irq
);
  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !coef_wr) |=> $stable(zero_out));
  // R3
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !irq_clr) |=> $stable(irq));
  // R5
  oneshot_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_out && !run_q && !coef_wr) |=> zero_out);
  // R5
  write_clears_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_wr |=> !zero_out);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !tick) |=> !irq);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq) |=> !irq);
endmodule

bind bit_rate_timer bit_rate_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .coef_wr(coef_wr),
  .mode_reload(mode_reload), .irq_en(irq_en), .irq_clr(irq_clr),
  .run_q(run_q), .zero_out(zero_out), .irq(irq)
);

// File: tb/bit_rate_timer_tb_top.sv
module bit_rate_timer_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, tick, coef_wr, mode_reload, irq_en, irq_clr;
  logic [7:0] coef_wdata;
  logic zero_out, irq;

  int nvec = 0, nbad = 0;

  logic [7:0] m_coef, m_left;
  logic       m_run, m_zero, m_irq;

  bit_rate_timer #(.CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .coef_wr(coef_wr),
    .coef_wdata(coef_wdata), .mode_reload(mode_reload), .irq_en(irq_en),
    .irq_clr(irq_clr), .zero_out(zero_out), .irq(irq)
  );

  function automatic logic expires(input logic [7:0] left);
    return left <= 8'd1;
  endfunction

  task automatic model_step();
    logic fire;
    fire = 1'b0;
    if (coef_wr) begin
      m_coef = coef_wdata; m_left = coef_wdata; m_run = 1'b1; m_zero = 1'b0;
    end else if (tick && m_run) begin
      fire = expires(m_left);
      m_zero = fire;
      if (!fire) m_left = m_left - 8'd1;
      else if (mode_reload) m_left = m_coef;
      else begin m_left = 8'd0; m_run = 1'b0; end
    end
    if (fire && irq_en) m_irq = 1'b1;
    else if (irq_clr)   m_irq = 1'b0;
  endtask

  task automatic check(input string tag);
    nvec++;
    if (zero_out !== m_zero) begin
      nbad++;
      $display("FAIL %s zero_out actual=%b expected=%b t=%0t", tag, zero_out, m_zero, $time);
    end
    nvec++;
    if (irq !== m_irq) begin
      nbad++;
      $display("FAIL %s irq actual=%b expected=%b t=%0t", tag, irq, m_irq, $time);
    end
  endtask

  task automatic cyc(input string tag, input bit t, input bit w, input logic [7:0] d, input bit clr);
    tick = t; coef_wr = w; coef_wdata = d; irq_clr = clr;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      cyc(tag, 1'b1, 1'b0, 8'd0, 1'b0);
      cyc(tag, 1'b0, 1'b0, 8'd0, 1'b0);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick = 0; coef_wr = 0; coef_wdata = 0;
    mode_reload = 0; irq_en = 0; irq_clr = 0;
    m_coef = 0; m_left = 0; m_run = 0; m_zero = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    ticks("R1", 3);

    mode_reload = 0; irq_en = 0;
    cyc("R2", 0, 1, 8'd3, 0);
    ticks("R2", 3);
    cyc("R3", 0, 0, 8'd0, 0);
    cyc("R3", 0, 0, 8'd0, 0);
    ticks("R5", 4);
    cyc("R5", 0, 1, 8'd5, 0);
    ticks("R5", 6);

    mode_reload = 1;
    cyc("R4", 0, 1, 8'd2, 0);
    ticks("R4", 8);
    cyc("R4", 0, 1, 8'd3, 0);
    ticks("R4", 9);

    cyc("R6", 0, 1, 8'd0, 0);
    ticks("R6", 4);
    mode_reload = 0;
    cyc("R6", 0, 1, 8'd0, 0);
    ticks("R6", 3);

    irq_en = 1;
    cyc("R7", 0, 1, 8'd1, 0);
    ticks("R7", 1);
    cyc("R7", 0, 0, 8'd0, 0);
    cyc("R8", 0, 0, 8'd0, 1);
    cyc("R8", 0, 1, 8'd1, 0);
    cyc("R8", 1, 0, 8'd0, 1);
    cyc("R8", 0, 0, 8'd0, 0);
    cyc("R9", 0, 0, 8'd0, 1);
    irq_en = 0;
    cyc("R9", 0, 1, 8'd1, 0);
    ticks("R9", 2);

    mode_reload = 1;
    cyc("R10", 0, 1, 8'd4, 0);
    ticks("R10", 3);
    cyc("R10", 1, 1, 8'd4, 0);
    ticks("R10", 5);

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 64) == 0) mode_reload = $urandom % 2;
      if (($urandom % 32) == 0) irq_en = $urandom % 2;
      cyc("R2/R4/R7 random", ($urandom % 3) == 0, ($urandom % 40) == 0,
          8'($urandom % 12), ($urandom % 16) == 0);
    end
    finish_run();
  end
endmodule